// File: doc/BRIEF.md
# Cascaded Match-Flag Lock-Out Controller

This block is the per-device control slice that lets several associative memory devices, stacked in a vertical chain, behave as one larger memory. Each stage takes the match and full flags from the device above it and merges them with its own local results. The merged flags go on to the next stage. As a result, the last stage in the chain reports the match and full state of the whole chain.

The controller also decides three things for each cycle: whether this device may drive read data, whether it may carry out a write, and whether it is the single device that acts on highest-priority-match operations. A chain lock is requested by holding `lock_req_n_i` low during one cycle. The lock is registered and applies from the following cycle. While the chain is locked, only the highest-priority matching device answers reads.

There are two unlock rules. In standard mode the lock survives until a non-functional cycle arrives with the request released. In enhanced mode the lock drops on any released cycle, and writes after a miss need no unlocking cycle. A device-select word either broadcasts to every device (all ones) or targets the one device whose page address equals it.

Top module: `casc_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge and the chain lock is cleared.
- R2: `match_dn_o` equals `match_up_i | match_loc_i` of the previous cycle.
- R3: `full_dn_o` equals `full_up_i & full_loc_i` of the previous cycle, so the last stage reads 1 only when every device is full.
- R4: A cycle with `lock_req_n_i` low locks the chain for the next cycle. While the chain is locked, a read is enabled only in the device with `match_up_i`=0 and `match_loc_i`=1.
- R5: `hp_act_o` is 1 one cycle after a cycle where the device is selected, `match_up_i`=0 and `match_loc_i`=1; otherwise it is 0.
- R6: `rd_oe_o` is 1 one cycle after a data read (code 3) or status read (code 4) cycle, but only when the device is selected and either the chain was unlocked or the device is the highest-priority matcher.
- R7: In standard mode (`enh_mode_i`=0), the lock stays set through any functional cycle (codes 1 to 4). It clears only after a non-functional cycle (codes 0, 5, 6, 7) with `lock_req_n_i` high.
- R8: In enhanced mode (`enh_mode_i`=1), the lock clears after any cycle with `lock_req_n_i` high. A command write or data write during a locked cycle proceeds if neither `match_up_i` nor `match_loc_i` is set.
- R9: The device is selected when `dev_sel_i` is 16'hFFFF or when `dev_sel_i` equals `page_addr_i`. An unselected device never raises `rd_oe_o`, `wr_en_o` or `hp_act_o`.
- R10: With `lock_req_n_i` held high after reset, a selected device is enabled for every read and write, whatever the match flags.
- R11: `wr_en_o` is 1 one cycle after a command write (code 1) or data write (code 2) cycle, but only when the device is selected and either the chain was unlocked, the device is the highest-priority matcher, or the enhanced-mode miss rule of R8 applies.
- R12: Cycle codes 0, 5, 6 and 7 enable neither reads nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_up_i | input | 1 | Match flag from the device above |
| full_up_i | input | 1 | Full flag from the device above (tie 1 in the first device) |
| match_loc_i | input | 1 | Local match result |
| full_loc_i | input | 1 | Local full result |
| lock_req_n_i | input | 1 | Active-low chain lock request, takes effect next cycle |
| cyc_i | input | 3 | Cycle type: 0 none, 1 command write, 2 data write, 3 data read, 4 status read, 5-7 none |
| enh_mode_i | input | 1 | 0 standard unlock rule, 1 enhanced unlock rule |
| dev_sel_i | input | 16 | Device-select word |
| page_addr_i | input | 16 | This device's page address |
| match_dn_o | output | 1 | Merged match flag to the next device |
| full_dn_o | output | 1 | Merged full flag to the next device |
| rd_oe_o | output | 1 | Read output enable |
| wr_en_o | output | 1 | Write execute enable |
| hp_act_o | output | 1 | Device is the active highest-priority matcher |

## Verification
A wrong merged flag appears on `match_dn_o` or `full_dn_o` one cycle after the inputs that caused it. A stuck or early-released lock has no effect of its own at the ports. It shows up only at the next read or write cycle, when `rd_oe_o` or `wr_en_o` takes the wrong value one cycle after that cycle. The bench therefore sets up lock, miss, targeted-select and unlock sequences in both modes, so that each lock error is followed by an access that reveals it.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int CYC_W = 3;

  typedef enum logic [CYC_W-1:0] {
    CYC_NONE  = 3'd0,
    CYC_CMDW  = 3'd1,
    CYC_DATW  = 3'd2,
    CYC_DATR  = 3'd3,
    CYC_STSR  = 3'd4
  } cyc_e;

  function automatic logic cyc_is_write(input logic [CYC_W-1:0] c);
    return (c == CYC_CMDW) || (c == CYC_DATW);
  endfunction

  function automatic logic cyc_is_read(input logic [CYC_W-1:0] c);
    return (c == CYC_DATR) || (c == CYC_STSR);
  endfunction

  // Codes outside 1..4 are non-functional cycles (R12)
  function automatic logic cyc_is_idle(input logic [CYC_W-1:0] c);
    return !(cyc_is_write(c) || cyc_is_read(c));
  endfunction
endpackage

// File: rtl/casc_sel.sv
module casc_sel #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] dev_sel,
  input  logic [SEL_W-1:0] page_addr,
  output logic             selected
);
  localparam logic [SEL_W-1:0] SEL_ALL = {SEL_W{1'b1}};

  logic bcast;
  logic target;

  // R9: broadcast word or exact page match
  assign bcast    = (dev_sel == SEL_ALL);
  assign target   = (dev_sel == page_addr);
  assign selected = bcast | target;
endmodule

// File: rtl/casc_lock.sv
module casc_lock (
  input  logic clk,
  input  logic rst,
  input  logic lock_req_n,
  input  logic idle_cyc,
  input  logic enh_mode,
  output logic lock_q
);
  logic hold;
  logic lock_d;

  // Standard mode keeps the lock through functional cycles (R7);
  // enhanced mode releases on any cycle without a request (R8)
  assign hold   = lock_q & ~enh_mode & ~idle_cyc;
  assign lock_d = ~lock_req_n | hold;

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_d;
  end
endmodule

// File: rtl/casc_gate.sv
module casc_gate
  import casc_pkg::*;
(
  input  logic             locked,
  input  logic             match_up,
  input  logic             match_loc,
  input  logic             selected,
  input  logic             enh_mode,
  input  logic [CYC_W-1:0] cyc,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             hp_ok
);
  logic owner;
  logic seen_miss;
  logic rd_pass;
  logic wr_pass;

  assign owner     = ~match_up & match_loc;
  assign seen_miss = ~match_up & ~match_loc;

  assign rd_pass = ~locked | owner;
  assign wr_pass = ~locked | owner | (enh_mode & seen_miss);

  assign rd_ok = selected & cyc_is_read(cyc)  & rd_pass;
  assign wr_ok = selected & cyc_is_write(cyc) & wr_pass;
  assign hp_ok = selected & owner;
endmodule

// File: rtl/casc_lock_ctrl.sv
module casc_lock_ctrl
  import casc_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             match_up_i,
  input  logic             full_up_i,
  input  logic             match_loc_i,
  input  logic             full_loc_i,
  input  logic             lock_req_n_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             enh_mode_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  input  logic [SEL_W-1:0] page_addr_i,
  output logic             match_dn_o,
  output logic             full_dn_o,
  output logic             rd_oe_o,
  output logic             wr_en_o,
  output logic             hp_act_o
);
  logic selected;
  logic lock_q;
  logic rd_ok, wr_ok, hp_ok;

  casc_sel #(.SEL_W(SEL_W)) u_sel (
    .dev_sel   (dev_sel_i),
    .page_addr (page_addr_i),
    .selected  (selected)
  );

  casc_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .lock_req_n (lock_req_n_i),
    .idle_cyc   (cyc_is_idle(cyc_i)),
    .enh_mode   (enh_mode_i),
    .lock_q     (lock_q)
  );

  casc_gate u_gate (
    .locked    (lock_q),
    .match_up  (match_up_i),
    .match_loc (match_loc_i),
    .selected  (selected),
    .enh_mode  (enh_mode_i),
    .cyc       (cyc_i),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .hp_ok     (hp_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_dn_o <= 1'b0;
      full_dn_o  <= 1'b0;
      rd_oe_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      hp_act_o   <= 1'b0;
    end else begin
      match_dn_o <= match_up_i | match_loc_i;
      full_dn_o  <= full_up_i & full_loc_i;
      rd_oe_o    <= rd_ok;
      wr_en_o    <= wr_ok;
      hp_act_o   <= hp_ok;
    end
  end
endmodule

// File: rtl/casc_lock_chk.sv
module casc_lock_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             match_up_i,
  input logic             full_up_i,
  input logic             match_loc_i,
  input logic             full_loc_i,
  input logic             lock_req_n_i,
  input logic [2:0]       cyc_i,
  input logic             enh_mode_i,
  input logic [SEL_W-1:0] dev_sel_i,
  input logic [SEL_W-1:0] page_addr_i,
  input logic             match_dn_o,
  input logic             full_dn_o,
  input logic             rd_oe_o,
  input logic             wr_en_o,
  input logic             hp_act_o,
  input logic             lock_q
);
  logic sel_now;
  assign sel_now = (dev_sel_i == {SEL_W{1'b1}}) || (dev_sel_i == page_addr_i);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!rd_oe_o && !wr_en_o && !hp_act_o && !match_dn_o && !full_dn_o && !lock_q));

  assert_match_merge_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (match_dn_o == $past(match_up_i || match_loc_i)));

  assert_full_merge_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (full_dn_o == $past(full_up_i && full_loc_i)));

  assert_lock_set_R4: assert property (@(posedge clk) disable iff (rst)
    !lock_req_n_i |=> lock_q);

  assert_hp_owner_R5: assert property (@(posedge clk) disable iff (rst)
    hp_act_o |-> ($past(match_loc_i) && !$past(match_up_i)));

  assert_rd_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_i != 3'd3 && cyc_i != 3'd4) |=> !rd_oe_o);

  assert_std_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !enh_mode_i && cyc_i >= 3'd1 && cyc_i <= 3'd4) |=> lock_q);

  assert_enh_release_R8: assert property (@(posedge clk) disable iff (rst)
    (enh_mode_i && lock_req_n_i) |=> !lock_q);

  assert_unselected_R9: assert property (@(posedge clk) disable iff (rst)
    !sel_now |=> (!rd_oe_o && !wr_en_o && !hp_act_o));

  assert_wr_on_write_R11: assert property (@(posedge clk) disable iff (rst)
    (cyc_i != 3'd1 && cyc_i != 3'd2) |=> !wr_en_o);

  assert_one_enable_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> !(rd_oe_o && wr_en_o));
endmodule

bind casc_lock_ctrl casc_lock_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .match_up_i(match_up_i), .full_up_i(full_up_i),
  .match_loc_i(match_loc_i), .full_loc_i(full_loc_i), .lock_req_n_i(lock_req_n_i),
  .cyc_i(cyc_i), .enh_mode_i(enh_mode_i), .dev_sel_i(dev_sel_i),
  .page_addr_i(page_addr_i), .match_dn_o(match_dn_o), .full_dn_o(full_dn_o),
  .rd_oe_o(rd_oe_o), .wr_en_o(wr_en_o), .hp_act_o(hp_act_o), .lock_q(lock_q)
);

// File: tb/sim_casc_lock_ctrl.sv
`timescale 1ns/1ps
module sim_casc_lock_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mu = 1'b0, fu = 1'b0, ml = 1'b0, fl = 1'b0, lrn = 1'b1, enh = 1'b0;
  logic [2:0]  cyc = 3'd0;
  logic [15:0] dsel = 16'hFFFF;
  logic [15:0] page = 16'h0005;
  logic o_m, o_f, o_rd, o_wr, o_hp;

  int errs = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  int m_lock = 0;
  int e_m = 0, e_f = 0, e_rd = 0, e_wr = 0, e_hp = 0;

  always #5 clk = ~clk;

  casc_lock_ctrl u0 (
    .clk(clk), .rst(rst), .match_up_i(mu), .full_up_i(fu), .match_loc_i(ml),
    .full_loc_i(fl), .lock_req_n_i(lrn), .cyc_i(cyc), .enh_mode_i(enh),
    .dev_sel_i(dsel), .page_addr_i(page), .match_dn_o(o_m), .full_dn_o(o_f),
    .rd_oe_o(o_rd), .wr_en_o(o_wr), .hp_act_o(o_hp)
  );

  // Behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    int sel, own, rd, wr, nlock;
    if (rst) begin
      e_m = 0; e_f = 0; e_rd = 0; e_wr = 0; e_hp = 0; m_lock = 0;
    end else begin
      sel = (dsel == 16'hFFFF || dsel == page) ? 1 : 0;
      own = (!mu && ml) ? 1 : 0;
      rd  = (cyc == 3 || cyc == 4) ? 1 : 0;
      wr  = (cyc == 1 || cyc == 2) ? 1 : 0;
      e_m  = (mu || ml) ? 1 : 0;
      e_f  = (fu && fl) ? 1 : 0;
      e_hp = sel && own;
      e_rd = sel && rd && (!m_lock || own);
      e_wr = sel && wr && (!m_lock || own || (enh && !mu && !ml));
      if (!lrn) nlock = 1;
      else if (enh) nlock = 0;
      else if (rd || wr) nlock = m_lock;
      else nlock = 0;
      m_lock = nlock;
    end
  end

  task automatic chk1(input string what, input string rq, input logic act, input int exp);
    checks++;
    if (act !== exp[0]) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk1("match_dn", "R2", o_m, e_m);
    chk1("full_dn", "R3", o_f, e_f);
    chk1("hp_act", "R5", o_hp, e_hp);
    chk1("rd_oe", {"R6 ", tag}, o_rd, e_rd);
    chk1("wr_en", {"R11 ", tag}, o_wr, e_wr);
  endtask

  // drive one cycle at a falling edge, check at the next falling edge
  task automatic step(input logic a_mu, input logic a_ml, input logic a_lrn,
                      input logic [2:0] a_cyc, input logic [15:0] a_sel);
    mu = a_mu; ml = a_ml; lrn = a_lrn; cyc = a_cyc; dsel = a_sel;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1";
    compare_all();                       // R1 reset outputs
    rst = 1'b0;
    // R2 R3: flag merging over all combinations
    tag = "R2";
    for (int i = 0; i < 16; i++) begin
      fu = i[2]; fl = i[3];
      step(i[0], i[1], 1'b1, 3'd0, 16'hFFFF);
    end
    fu = 1'b0; fl = 1'b0;
    // R9: broadcast, targeted hit, targeted miss
    tag = "R9";
    step(1'b0, 1'b1, 1'b1, 3'd3, 16'hFFFF);
    step(1'b0, 1'b1, 1'b1, 3'd4, 16'h0005);
    step(1'b0, 1'b1, 1'b1, 3'd1, 16'h0006);
    step(1'b0, 1'b1, 1'b1, 3'd2, 16'h0005);
    // R4: lock then read from non-owner, then owner
    tag = "R4";
    step(1'b0, 1'b0, 1'b0, 3'd0, 16'hFFFF);
    step(1'b1, 1'b1, 1'b0, 3'd4, 16'hFFFF);
    step(1'b0, 1'b1, 1'b0, 3'd4, 16'hFFFF);
    // R7: standard mode miss holds lock until idle cycle
    tag = "R7";
    enh = 1'b0;
    step(1'b0, 1'b0, 1'b1, 3'd3, 16'hFFFF);
    step(1'b0, 1'b0, 1'b1, 3'd2, 16'hFFFF);
    step(1'b0, 1'b0, 1'b1, 3'd1, 16'hFFFF);
    step(1'b0, 1'b0, 1'b1, 3'd0, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 3'd3, 16'hFFFF);
    // R8: enhanced mode write after miss, release on any cycle
    tag = "R8";
    enh = 1'b1;
    step(1'b0, 1'b0, 1'b0, 3'd0, 16'hFFFF);
    step(1'b0, 1'b0, 1'b1, 3'd2, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 3'd3, 16'hFFFF);
    step(1'b0, 1'b0, 1'b0, 3'd3, 16'hFFFF);
    step(1'b1, 1'b1, 1'b1, 3'd1, 16'hFFFF);
    step(1'b1, 1'b1, 1'b1, 3'd4, 16'hFFFF);
    enh = 1'b0;
    // R12: codes 5..7 enable nothing and release a standard lock
    tag = "R12";
    step(1'b0, 1'b0, 1'b0, 3'd5, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 3'd6, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 3'd7, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 3'd3, 16'hFFFF);
    // R10: request held high, any match pattern
    tag = "R10";
    for (int i = 0; i < 16; i++)
      step(i[0], i[1], 1'b1, 3'd1 + 3'(i % 4), 16'h0005);
    // mixed random traffic
    tag = "RND";
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] s;
      int k = $urandom % 3;
      s = (k == 0) ? 16'hFFFF : (k == 1) ? page : 16'($urandom);
      enh = ($urandom % 8) == 0 ? ~enh : enh;
      fu = 1'($urandom); fl = 1'($urandom);
      step(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 3'($urandom), s);
    end
    // R1 again: mid-run reset clears lock
    tag = "R1";
    step(1'b0, 1'b0, 1'b0, 3'd0, 16'hFFFF);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 3'd3, 16'hFFFF);
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b1, 3'd3, 16'hFFFF);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule